// File: doc/BRIEF.md
# Switchable Command/Address Pipeline Stage

This block sits between a memory controller's command outputs and the command and address pins of a synchronous DRAM array. It forwards chip selects, the row, column and write strobes, clock enable, bank and multiplexed address. A mode control picks one of two paths. In the pass path the bundle goes straight through with no clock delay. In the pipe path the bundle is captured on the rising clock edge and appears at the memory one cycle later.

In pipe mode the command reaches the memory one cycle after the controller issues it, and the write data bus is not part of that command register. The block therefore delays write data and byte masks by the same cycle, so the controller can present data in the same relation to its write command in either mode. The read latency the controller must wait for grows by one cycle in pipe mode, and the block outputs that adjusted value.

After reset the stage comes up in pipe mode. A mode request is a level. The block applies it only on a clock edge where neither the incoming command nor the command held in the pipe register is a real command, so no command is repeated or dropped when the path length changes.

Top module: `cmd_stage`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the stage is in pipe mode. The memory side shows all chip selects high, row, column and write strobes high, clock enable high, bank and address zero, write data zero and every mask bit high.
- R2: In pass mode, every memory-side command, address, write data and mask output equals the matching host input in the same cycle.
- R3: In pipe mode, every memory-side command and address output equals the host input captured at the previous rising clock edge.
- R4: Write data and byte masks follow the command path delay. In pipe mode they equal the host values of the previous rising edge. In pass mode they equal the current host values.
- R5: A request for a different mode takes effect at a rising edge only if, at that edge, both the host command and the command held in the pipe register are idle. Idle means both chip-select bits are high, or the row, column and write strobes are all high. A request of 1 selects pipe mode and 0 selects pass mode.
- R6: A mode request refused under R5 stays pending while the request level is held, and it takes effect at the first later edge that meets the idle condition.
- R7: The exported host read latency equals the memory CAS latency input plus one in pipe mode, and equals it unchanged in pass mode.
- R8: In pipe mode, changes on the host inputs between rising edges do not change the memory-side outputs until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 1 | Requested mode: 1 pipe, 0 pass |
| mem_cl | input | CL_W | CAS latency programmed in the memory |
| h_cs_n | input | NUM_CS | Host chip selects, active low |
| h_ras_n | input | 1 | Host row strobe, active low |
| h_cas_n | input | 1 | Host column strobe, active low |
| h_we_n | input | 1 | Host write strobe, active low |
| h_cke | input | 1 | Host clock enable |
| h_ba | input | BANK_W | Host bank address |
| h_addr | input | ADDR_W | Host row/column address |
| h_wdata | input | DATA_W | Host write data |
| h_wmask | input | DATA_W/8 | Host byte write masks, 1 blocks a byte |
| m_cs_n | output | NUM_CS | Memory chip selects |
| m_ras_n | output | 1 | Memory row strobe |
| m_cas_n | output | 1 | Memory column strobe |
| m_we_n | output | 1 | Memory write strobe |
| m_cke | output | 1 | Memory clock enable |
| m_ba | output | BANK_W | Memory bank address |
| m_addr | output | ADDR_W | Memory address |
| m_wdata | output | DATA_W | Realigned write data |
| m_wmask | output | DATA_W/8 | Realigned byte masks |
| host_cl | output | CL_W+1 | Read latency seen by the host |

## Verification
The bench builds the stage with two chip selects, a 16-bit data path and a 3-bit latency field. With those sizes, every combination of chip selects, the three strobes and clock enable forms a 64-entry sweep, and the bench runs that sweep in both modes and again while the mode request toggles. Narrow fields let mode switches be attempted against every mix of an idle or active host command and an idle or active pipe register, including refused requests that wait. A separate phase changes the host inputs between edges in pipe mode to show that only the rising edge samples them.

// File: rtl/cmdstage_pkg.sv
package cmdstage_pkg;

    typedef enum logic {
        MODE_PASS = 1'b0,
        MODE_PIPE = 1'b1
    } stage_mode_e;

    typedef struct packed {
        logic cke;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBE_RESET = '{cke: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // A command slot carries no operation if no rank is selected or all strobes are high
    function automatic logic slot_is_idle(input logic no_rank, input strobe_t s);
        return no_rank || (s.ras_n && s.cas_n && s.we_n);
    endfunction

endpackage

// File: rtl/cmd_pipe.sv
module cmd_pipe
    import cmdstage_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CS-1:0] cs_n_i,
    input  strobe_t           strb_i,
    input  logic [BANK_W-1:0] ba_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NUM_CS-1:0] cs_n_o,
    output strobe_t           strb_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              idle_o
);

    typedef struct packed {
        logic [NUM_CS-1:0] cs_n;
        strobe_t           strb;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
    } cmd_slot_t;

    localparam cmd_slot_t SLOT_RESET = '{
        cs_n: {NUM_CS{1'b1}},
        strb: STROBE_RESET,
        ba:   '0,
        addr: '0
    };

    cmd_slot_t slot_d, slot_q;

    always_comb begin
        slot_d      = slot_q;
        slot_d.cs_n = cs_n_i;
        slot_d.strb = strb_i;
        slot_d.ba   = ba_i;
        slot_d.addr = addr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= SLOT_RESET;
        else        slot_q <= slot_d;
    end

    assign cs_n_o = slot_q.cs_n;
    assign strb_o = slot_q.strb;
    assign ba_o   = slot_q.ba;
    assign addr_o = slot_q.addr;
    assign idle_o = slot_is_idle(&slot_q.cs_n, slot_q.strb);

    // R1
    reset_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&cs_n_o && strb_o == STROBE_RESET && ba_o == '0 && addr_o == '0));

endmodule

// File: rtl/wdata_align.sv
module wdata_align
    import cmdstage_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stage_mode_e       mode_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W/LANE_W-1:0] wmask_i,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W/LANE_W-1:0] wmask_o
);

    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        typedef struct packed {
            logic [LANE_W-1:0] data;
            logic              mask;
        } lane_t;

        lane_t lane_d, lane_q;

        always_comb begin
            lane_d      = lane_q;
            lane_d.data = wdata_i[g*LANE_W +: LANE_W];
            lane_d.mask = wmask_i[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '{data: '0, mask: 1'b1};
            else        lane_q <= lane_d;
        end

        always_comb begin
            if (mode_i == MODE_PIPE) begin
                wdata_o[g*LANE_W +: LANE_W] = lane_q.data;
                wmask_o[g]                  = lane_q.mask;
            end else begin
                wdata_o[g*LANE_W +: LANE_W] = wdata_i[g*LANE_W +: LANE_W];
                wmask_o[g]                  = wmask_i[g];
            end
        end
    end

endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
    import cmdstage_pkg::*;
#(
    parameter int CL_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_req_i,
    input  logic          in_idle_i,
    input  logic          pipe_idle_i,
    input  logic [CL_W-1:0] mem_cl_i,
    output stage_mode_e   mode_o,
    output logic [CL_W:0] host_cl_o
);

    typedef struct packed {
        stage_mode_e mode;
        logic        warm;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    stage_mode_e req_mode;

    always_comb begin
        req_mode    = mode_req_i ? MODE_PIPE : MODE_PASS;
        ctrl_d      = ctrl_q;
        ctrl_d.warm = 1'b1;
        if (req_mode != ctrl_q.mode && in_idle_i && pipe_idle_i) begin
            ctrl_d.mode = req_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{mode: MODE_PIPE, warm: 1'b0};
        else        ctrl_q <= ctrl_d;
    end

    assign mode_o    = ctrl_q.mode;
    assign host_cl_o = {1'b0, mem_cl_i} + {{CL_W{1'b0}}, (ctrl_q.mode == MODE_PIPE)};

    // R5
    switch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.warm && mode_o != $past(mode_o)) |-> $past(in_idle_i && pipe_idle_i));

endmodule

// File: rtl/cmd_stage.sv
module cmd_stage
    import cmdstage_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16,
    parameter int CL_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_req,
    input  logic [CL_W-1:0]     mem_cl,
    input  logic [NUM_CS-1:0]   h_cs_n,
    input  logic                h_ras_n,
    input  logic                h_cas_n,
    input  logic                h_we_n,
    input  logic                h_cke,
    input  logic [BANK_W-1:0]   h_ba,
    input  logic [ADDR_W-1:0]   h_addr,
    input  logic [DATA_W-1:0]   h_wdata,
    input  logic [DATA_W/8-1:0] h_wmask,
    output logic [NUM_CS-1:0]   m_cs_n,
    output logic                m_ras_n,
    output logic                m_cas_n,
    output logic                m_we_n,
    output logic                m_cke,
    output logic [BANK_W-1:0]   m_ba,
    output logic [ADDR_W-1:0]   m_addr,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wmask,
    output logic [CL_W:0]       host_cl
);

    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    strobe_t             h_strb, p_strb;
    logic [NUM_CS-1:0]   p_cs_n;
    logic [BANK_W-1:0]   p_ba;
    logic [ADDR_W-1:0]   p_addr;
    logic                p_idle, h_idle;
    stage_mode_e         mode;
    logic                warm_q;

    assign h_strb = '{cke: h_cke, ras_n: h_ras_n, cas_n: h_cas_n, we_n: h_we_n};
    assign h_idle = slot_is_idle(&h_cs_n, h_strb);

    cmd_pipe #(
        .NUM_CS (NUM_CS),
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W)
    ) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n_i (h_cs_n),
        .strb_i (h_strb),
        .ba_i   (h_ba),
        .addr_i (h_addr),
        .cs_n_o (p_cs_n),
        .strb_o (p_strb),
        .ba_o   (p_ba),
        .addr_o (p_addr),
        .idle_o (p_idle)
    );

    mode_ctrl #(
        .CL_W (CL_W)
    ) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_req_i  (mode_req),
        .in_idle_i   (h_idle),
        .pipe_idle_i (p_idle),
        .mem_cl_i    (mem_cl),
        .mode_o      (mode),
        .host_cl_o   (host_cl)
    );

    wdata_align #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_wdata (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .wdata_i (h_wdata),
        .wmask_i (h_wmask[LANES-1:0]),
        .wdata_o (m_wdata),
        .wmask_o (m_wmask[LANES-1:0])
    );

    always_comb begin
        if (mode == MODE_PIPE) begin
            m_cs_n  = p_cs_n;
            m_ras_n = p_strb.ras_n;
            m_cas_n = p_strb.cas_n;
            m_we_n  = p_strb.we_n;
            m_cke   = p_strb.cke;
            m_ba    = p_ba;
            m_addr  = p_addr;
        end else begin
            m_cs_n  = h_cs_n;
            m_ras_n = h_ras_n;
            m_cas_n = h_cas_n;
            m_we_n  = h_we_n;
            m_cke   = h_cke;
            m_ba    = h_ba;
            m_addr  = h_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PASS) |->
        ({m_cs_n, m_ras_n, m_cas_n, m_we_n, m_cke, m_ba, m_addr, m_wdata, m_wmask} ==
         {h_cs_n, h_ras_n, h_cas_n, h_we_n, h_cke, h_ba, h_addr, h_wdata, h_wmask}));

    // R3
    pipe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q && mode == MODE_PIPE && $past(mode) == MODE_PIPE) |->
        ({m_cs_n, m_ras_n, m_cas_n, m_we_n, m_cke, m_ba, m_addr} ==
         $past({h_cs_n, h_ras_n, h_cas_n, h_we_n, h_cke, h_ba, h_addr})));

    // R4
    wdata_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q && mode == MODE_PIPE && $past(mode) == MODE_PIPE) |->
        ({m_wdata, m_wmask} == $past({h_wdata, h_wmask})));

    // R7
    host_cl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PIPE) |-> (host_cl == {1'b0, mem_cl} + 1'b1));

endmodule

// File: tb/test_cmd_stage.sv
module test_cmd_stage;

    localparam int NUM_CS = 2;
    localparam int BANK_W = 2;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 16;
    localparam int CL_W   = 3;
    localparam int CMD_W  = NUM_CS + 4 + BANK_W + ADDR_W;
    localparam int DAT_W  = DATA_W + DATA_W/8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_req = 1'b1;
    logic [CL_W-1:0] mem_cl = '0;
    logic [NUM_CS-1:0] h_cs_n = '1;
    logic h_ras_n = 1'b1, h_cas_n = 1'b1, h_we_n = 1'b1, h_cke = 1'b1;
    logic [BANK_W-1:0] h_ba = '0;
    logic [ADDR_W-1:0] h_addr = '0;
    logic [DATA_W-1:0] h_wdata = '0;
    logic [DATA_W/8-1:0] h_wmask = '0;
    logic [NUM_CS-1:0] m_cs_n;
    logic m_ras_n, m_cas_n, m_we_n, m_cke;
    logic [BANK_W-1:0] m_ba;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_wdata;
    logic [DATA_W/8-1:0] m_wmask;
    logic [CL_W:0] host_cl;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // Command vector layout: {cs_n, ras_n, cas_n, we_n, cke, ba, addr}
    logic [CMD_W-1:0] exp_prev_cmd;
    logic [DAT_W-1:0] exp_prev_dat;
    logic exp_mode;

    localparam logic [CMD_W-1:0] CMD_RESET = {{NUM_CS{1'b1}}, 4'b1111, {BANK_W{1'b0}}, {ADDR_W{1'b0}}};
    localparam logic [DAT_W-1:0] DAT_RESET = {{DATA_W{1'b0}}, {(DATA_W/8){1'b1}}};

    always #5 clk = ~clk;

    cmd_stage #(
        .NUM_CS (NUM_CS), .BANK_W (BANK_W), .ADDR_W (ADDR_W),
        .DATA_W (DATA_W), .CL_W (CL_W)
    ) i_cmd_stage (
        .clk (clk), .rst_n (rst_n), .mode_req (mode_req), .mem_cl (mem_cl),
        .h_cs_n (h_cs_n), .h_ras_n (h_ras_n), .h_cas_n (h_cas_n), .h_we_n (h_we_n),
        .h_cke (h_cke), .h_ba (h_ba), .h_addr (h_addr), .h_wdata (h_wdata), .h_wmask (h_wmask),
        .m_cs_n (m_cs_n), .m_ras_n (m_ras_n), .m_cas_n (m_cas_n), .m_we_n (m_we_n),
        .m_cke (m_cke), .m_ba (m_ba), .m_addr (m_addr), .m_wdata (m_wdata), .m_wmask (m_wmask),
        .host_cl (host_cl)
    );

    function automatic logic [CMD_W-1:0] out_cmd();
        return {m_cs_n, m_ras_n, m_cas_n, m_we_n, m_cke, m_ba, m_addr};
    endfunction

    function automatic logic cmd_idle(input logic [CMD_W-1:0] c);
        return (&c[CMD_W-1 -: NUM_CS]) || (&c[CMD_W-NUM_CS-1 -: 3]);
    endfunction

    function automatic logic [CMD_W-1:0] pat_cmd(input int p);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(p * 97 + 5);
        return {p[1:0], p[4:2], p[5], BANK_W'(p[5:4] ^ p[1:0]), a};
    endfunction

    function automatic logic [DAT_W-1:0] pat_dat(input int p);
        logic [DATA_W-1:0] d;
        d = DATA_W'(p * 16'h0123) ^ 16'h5a5a;
        return {d, p[2:1]};
    endfunction

    task automatic check(input string req, input logic [CMD_W+DAT_W-1:0] act,
                         input logic [CMD_W+DAT_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [CMD_W-1:0] c, input logic [DAT_W-1:0] d);
        {h_cs_n, h_ras_n, h_cas_n, h_we_n, h_cke, h_ba, h_addr} = c;
        {h_wdata, h_wmask} = d;
    endtask

    // One cycle: drive at the falling edge, sample 2 ns later, then advance the model
    task automatic step(input logic [CMD_W-1:0] c, input logic [DAT_W-1:0] d,
                        input logic req, input logic [CL_W-1:0] cl);
        @(negedge clk);
        drive(c, d);
        mode_req = req;
        mem_cl = cl;
        #2;
        if (exp_mode) begin
            check("R3", {{DAT_W{1'b0}}, out_cmd()}, {{DAT_W{1'b0}}, exp_prev_cmd});
            check("R4", {{CMD_W{1'b0}}, m_wdata, m_wmask}, {{CMD_W{1'b0}}, exp_prev_dat});
        end else begin
            check("R2", {{DAT_W{1'b0}}, out_cmd()}, {{DAT_W{1'b0}}, c});
            check("R4", {{CMD_W{1'b0}}, m_wdata, m_wmask}, {{CMD_W{1'b0}}, d});
        end
        check("R7", (CMD_W+DAT_W)'(host_cl), (CMD_W+DAT_W)'({1'b0, cl} + exp_mode));
        if (req != exp_mode && cmd_idle(c) && cmd_idle(exp_prev_cmd)) exp_mode = req;
        exp_prev_cmd = c;
        exp_prev_dat = d;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [CMD_W-1:0] act_cmd;
        exp_prev_cmd = CMD_RESET;
        exp_prev_dat = DAT_RESET;
        exp_mode = 1'b1;

        // R1: reset state, with an active command on the host side
        drive({CMD_W{1'b0}}, {DAT_W{1'b0}});
        mem_cl = 3'd2;
        #12;
        check("R1", {{DAT_W{1'b0}}, out_cmd()}, {{DAT_W{1'b0}}, CMD_RESET});
        check("R1", {{CMD_W{1'b0}}, m_wdata, m_wmask}, {{CMD_W{1'b0}}, DAT_RESET});
        check("R1", (CMD_W+DAT_W)'(host_cl), (CMD_W+DAT_W)'(3));
        @(negedge clk);
        drive(CMD_RESET, DAT_RESET);
        rst_n = 1'b1;
        #2;
        check("R1", {{DAT_W{1'b0}}, out_cmd()}, {{DAT_W{1'b0}}, CMD_RESET});

        // Pipe-mode sweep over all strobe/select/enable combinations
        for (int p = 0; p < 64; p++) step(pat_cmd(p), pat_dat(p), 1'b1, CL_W'(p));

        // R5/R6: switch to pass, refused while commands are in flight
        act_cmd = pat_cmd(0);
        step(act_cmd, pat_dat(1), 1'b0, 3'd2);
        step(act_cmd, pat_dat(2), 1'b0, 3'd2);
        step(CMD_RESET, pat_dat(3), 1'b0, 3'd2);
        check("R6", {{(CMD_W+DAT_W-1){1'b0}}, exp_mode}, {{(CMD_W+DAT_W-1){1'b0}}, 1'b1});
        step(CMD_RESET, pat_dat(4), 1'b0, 3'd2);
        check("R5", {{(CMD_W+DAT_W-1){1'b0}}, exp_mode}, {{(CMD_W+DAT_W-1){1'b0}}, 1'b0});

        // Pass-mode sweep
        for (int p = 0; p < 64; p++) step(pat_cmd(p), pat_dat(p), 1'b0, CL_W'(p + 3));

        // R5/R6: switch back to pipe
        step(act_cmd, pat_dat(5), 1'b1, 3'd3);
        step(act_cmd, pat_dat(6), 1'b1, 3'd3);
        step(CMD_RESET, pat_dat(7), 1'b1, 3'd3);
        step(CMD_RESET, pat_dat(8), 1'b1, 3'd3);
        step(act_cmd, pat_dat(9), 1'b1, 3'd3);

        // R8: mid-cycle input changes in pipe mode
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            drive(pat_cmd(p), pat_dat(p));
            #2;
            check("R8", {{DAT_W{1'b0}}, out_cmd()}, {{DAT_W{1'b0}}, exp_prev_cmd});
            #1;
            drive(pat_cmd(p + 20), pat_dat(p + 20));
            #1;
            check("R8", {{DAT_W{1'b0}}, out_cmd()}, {{DAT_W{1'b0}}, exp_prev_cmd});
            check("R8", {{CMD_W{1'b0}}, m_wdata, m_wmask}, {{CMD_W{1'b0}}, exp_prev_dat});
            exp_prev_cmd = pat_cmd(p + 20);
            exp_prev_dat = pat_dat(p + 20);
        end

        // R5/R6: requests toggling against mixed idle and active traffic
        for (int p = 0; p < 128; p++) begin
            step(pat_cmd((p * 7) % 64), pat_dat(p), p[0] ^ p[3], CL_W'(p));
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule